// File: doc/BRIEF.md
# Paged Message Record and Playback Sequencer

This block steers the addressing of a page-organised message memory while a message is being recorded or played back. Each page is split into 32 blocks, and the blocks are taken four at a time as groups, so a page has eight groups. A recording always begins at block 0 of a chosen page. From there the sequencer walks forward one block per tick and continues into following pages. A stop request ends a recording only at the close of a group. The sequencer then marks that group with an end-of-message bit, which it keeps in a store of its own with eight bits per page.

Playback starts on a page in the same way and walks through the same blocks. It raises a one-cycle message-finished interrupt when it completes a group whose end-of-message bit is set. The sequencer does not time samples and does not store audio. It is paced by a block-complete tick from the data path, and it reports the current page and block so that the data path can address the array.

Top module: `page_rec_seq`

## Requirements
- R1: After reset the sequencer is idle. rec_active, play_active, rec_done, msg_end_irq and addr_err are 0, and cur_page and cur_block are 0.
- R2: A record command given while idle with start_page below 1888 makes rec_active 1 on the next cycle, with cur_page equal to start_page and cur_block equal to 0.
- R3: Each blk_tick while active advances cur_block by one. A tick on block 31 moves to block 0 of the next page, and a tick on block 31 of page 1887 moves to page 0.
- R4: A record or play command given while idle with start_page of 1888 or more is refused. The sequencer stays idle and addr_err becomes 1. addr_err holds until a later command is accepted, which clears it.
- R5: A stop received during a group does not end the recording at once. Blocks keep advancing until the tick that completes the last block of the group, that is a block whose low two bits are 3. On that tick rec_done pulses for one cycle and rec_active drops, and cur_page and cur_block keep the last recorded block.
- R6: A stop that arrives in the same cycle as the tick completing the last block of a group ends the recording on that tick, without recording a further group.
- R7: A recording that ends sets the end-of-message bit of its final group. A later playback raises msg_end_irq for one cycle on the tick that completes that group's last block, and then returns to idle.
- R8: Recording into a group clears any end-of-message bit left in that group by an earlier recording, so a later playback passes over it without an interrupt.
- R9: Playback continues across page boundaries through groups whose end-of-message bit is clear.
- R10: Record and play commands are ignored while a recording or playback is running. A stop during playback ends it on the next cycle without an interrupt and leaves cur_block unchanged.
- R11: msg_end_irq and rec_done are never 1 in the same cycle, and rec_active and play_active are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_rec | input | 1 | Start recording at start_page (one-cycle pulse) |
| cmd_play | input | 1 | Start playback at start_page (one-cycle pulse) |
| cmd_stop | input | 1 | Stop request |
| start_page | input | 11 | Page used by a record or play command |
| blk_tick | input | 1 | The current block has completed |
| rec_active | output | 1 | Recording in progress |
| play_active | output | 1 | Playback in progress |
| cur_page | output | 11 | Current page address |
| cur_block | output | 5 | Current block within the page |
| rec_done | output | 1 | One-cycle pulse when a recording has ended |
| msg_end_irq | output | 1 | One-cycle message-finished interrupt |
| addr_err | output | 1 | The last start command named a page out of range |

## Verification
The stale-marker case is the hardest to reach from the ports. The end-of-message store cannot be read directly, so the only way to see it is to lay down one recording that leaves a marker in an early group, record over that group with a longer message, and play back. The interrupt must then skip the old group and fire on the new final group. The page-wrap path also needs 32 ticks from page 1887 before it shows. The cross-page playback case needs a recording that spans two pages before it can be played back.

// File: rtl/prs_pkg.sv
package prs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REC  = 2'd1,
    ST_PLAY = 2'd2
  } seq_state_e;

endpackage

// File: rtl/prs_addr_ctr.sv
// Page and block position counter: loads a page at block 0, steps per block.
module prs_addr_ctr #(
  parameter int NUM_PAGES    = 1888,
  parameter int PAGE_AW      = 11,
  parameter int BLK_PER_PAGE = 32,
  parameter int BLK_AW       = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [PAGE_AW-1:0] load_page_i,
  input  logic               adv_i,
  output logic [PAGE_AW-1:0] page_o,
  output logic [BLK_AW-1:0]  blk_o
);

  localparam logic [BLK_AW-1:0]  BLK_MAX   = BLK_AW'(BLK_PER_PAGE - 1);
  localparam logic [PAGE_AW-1:0] LAST_PAGE = PAGE_AW'(NUM_PAGES - 1);

  logic [PAGE_AW-1:0] page_q, page_d;
  logic [BLK_AW-1:0]  blk_q, blk_d;
  logic               ctr_en;

  assign ctr_en = load_i | adv_i;

  always_comb begin
    page_d = page_q;
    blk_d  = blk_q;
    if (load_i) begin
      page_d = load_page_i;
      blk_d  = '0;
    end else if (adv_i) begin
      if (blk_q == BLK_MAX) begin
        blk_d  = '0;
        page_d = (page_q == LAST_PAGE) ? '0 : page_q + 1'b1;
      end else begin
        blk_d = blk_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      blk_q  <= '0;
    end else if (ctr_en) begin
      page_q <= page_d;
      blk_q  <= blk_d;
    end
  end

  assign page_o = page_q;
  assign blk_o  = blk_q;

  AST_LOAD_AT_BLOCK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (blk_q == '0)); // R2

  AST_STEP_ONE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && blk_q != BLK_MAX) |=> (blk_q == $past(blk_q) + 1'b1) && $stable(page_q)); // R3

  AST_PAGE_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && blk_q == BLK_MAX && page_q == LAST_PAGE) |=> (page_q == '0) && (blk_q == '0)); // R3

  AST_PAGE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, page_q} < (PAGE_AW + 1)'(NUM_PAGES)); // R3

endmodule

// File: rtl/prs_eom_store.sv
// One end-of-message bit per group; single bit-write port, whole-row read.
module prs_eom_store #(
  parameter int NUM_PAGES    = 1888,
  parameter int PAGE_AW      = 11,
  parameter int GRP_PER_PAGE = 8,
  parameter int GRP_AW       = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_i,
  input  logic [PAGE_AW-1:0]      wpage_i,
  input  logic [GRP_AW-1:0]       wgrp_i,
  input  logic                    wbit_i,
  input  logic [PAGE_AW-1:0]      rpage_i,
  output logic [GRP_PER_PAGE-1:0] rrow_o
);

  logic [GRP_PER_PAGE-1:0] mark_mem [NUM_PAGES];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mark_mem[wpage_i][wgrp_i] <= wbit_i;
    end
  end

  assign rrow_o = mark_mem[rpage_i];

  AST_WRITE_PAGE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> ({1'b0, wpage_i} < (PAGE_AW + 1)'(NUM_PAGES))); // R7

endmodule

// File: rtl/prs_ctrl.sv
// Record/playback control: start checks, deferred stop, marker writes, interrupt.
module prs_ctrl
  import prs_pkg::*;
#(
  parameter int NUM_PAGES    = 1888,
  parameter int PAGE_AW      = 11,
  parameter int BLK_AW       = 5,
  parameter int SUB_AW       = 2,
  parameter int GRP_PER_PAGE = 8,
  parameter int GRP_AW       = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_rec_i,
  input  logic                    cmd_play_i,
  input  logic                    cmd_stop_i,
  input  logic [PAGE_AW-1:0]      start_page_i,
  input  logic                    blk_tick_i,
  input  logic [BLK_AW-1:0]       cur_blk_i,
  input  logic [GRP_PER_PAGE-1:0] eom_row_i,
  output logic                    ctr_load_o,
  output logic                    ctr_adv_o,
  output logic                    eom_we_o,
  output logic                    eom_wbit_o,
  output logic                    rec_active_o,
  output logic                    play_active_o,
  output logic                    rec_done_o,
  output logic                    msg_irq_o,
  output logic                    addr_err_o
);

  seq_state_e        state_q, state_d;
  logic              stop_pend_q, stop_pend_d;
  logic              clr_pend_q, clr_pend_d;
  logic              done_q, done_d;
  logic              irq_q, irq_d;
  logic              err_q, err_d;

  logic [GRP_AW-1:0] cur_grp;
  logic              grp_end;
  logic              page_ok;
  logic              stop_now;
  logic              eom_hit;

  assign cur_grp  = cur_blk_i[BLK_AW-1:SUB_AW];
  assign grp_end  = &cur_blk_i[SUB_AW-1:0];
  assign page_ok  = {1'b0, start_page_i} < (PAGE_AW + 1)'(NUM_PAGES);
  assign stop_now = stop_pend_q | cmd_stop_i;
  assign eom_hit  = eom_row_i[cur_grp];

  always_comb begin
    state_d     = state_q;
    stop_pend_d = stop_pend_q;
    clr_pend_d  = clr_pend_q;
    done_d      = 1'b0;
    irq_d       = 1'b0;
    err_d       = err_q;
    ctr_load_o  = 1'b0;
    ctr_adv_o   = 1'b0;
    eom_we_o    = 1'b0;
    eom_wbit_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_rec_i || cmd_play_i) begin
          if (page_ok) begin
            ctr_load_o  = 1'b1;
            err_d       = 1'b0;
            stop_pend_d = 1'b0;
            if (cmd_rec_i) begin
              state_d    = ST_REC;
              clr_pend_d = 1'b1;
            end else begin
              state_d = ST_PLAY;
            end
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_REC: begin
        // wipe a leftover marker in the group just entered
        if (clr_pend_q) begin
          eom_we_o   = 1'b1;
          eom_wbit_o = 1'b0;
          clr_pend_d = 1'b0;
        end
        if (blk_tick_i) begin
          if (grp_end && stop_now) begin
            eom_we_o    = 1'b1;
            eom_wbit_o  = 1'b1;
            state_d     = ST_IDLE;
            done_d      = 1'b1;
            stop_pend_d = 1'b0;
          end else begin
            ctr_adv_o = 1'b1;
            if (grp_end) clr_pend_d = 1'b1;
            if (cmd_stop_i) stop_pend_d = 1'b1;
          end
        end else if (cmd_stop_i) begin
          stop_pend_d = 1'b1;
        end
      end
      ST_PLAY: begin
        if (cmd_stop_i) begin
          state_d = ST_IDLE;
        end else if (blk_tick_i) begin
          if (grp_end && eom_hit) begin
            state_d = ST_IDLE;
            irq_d   = 1'b1;
          end else begin
            ctr_adv_o = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      stop_pend_q <= 1'b0;
      clr_pend_q  <= 1'b0;
      done_q      <= 1'b0;
      irq_q       <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      stop_pend_q <= stop_pend_d;
      clr_pend_q  <= clr_pend_d;
      done_q      <= done_d;
      irq_q       <= irq_d;
      err_q       <= err_d;
    end
  end

  assign rec_active_o  = (state_q == ST_REC);
  assign play_active_o = (state_q == ST_PLAY);
  assign rec_done_o    = done_q;
  assign msg_irq_o     = irq_q;
  assign addr_err_o    = err_q;

  AST_IRQ_AFTER_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(state_q) == ST_PLAY)); // R7

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R7

  AST_DONE_ON_GROUP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(blk_tick_i && grp_end)); // R5

  AST_MARK_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (eom_we_o && eom_wbit_o) |-> (stop_pend_q || cmd_stop_i)); // R6

  AST_ERR_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (state_q == ST_IDLE)); // R4

  AST_DONE_IRQ_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && irq_q)); // R11

endmodule

// File: rtl/page_rec_seq.sv
module page_rec_seq #(
  parameter int NUM_PAGES    = 1888,
  parameter int PAGE_AW      = 11,
  parameter int BLK_PER_PAGE = 32,
  parameter int BLK_PER_GRP  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cmd_rec,
  input  logic                              cmd_play,
  input  logic                              cmd_stop,
  input  logic [PAGE_AW-1:0]                start_page,
  input  logic                              blk_tick,
  output logic                              rec_active,
  output logic                              play_active,
  output logic [PAGE_AW-1:0]                cur_page,
  output logic [$clog2(BLK_PER_PAGE)-1:0]   cur_block,
  output logic                              rec_done,
  output logic                              msg_end_irq,
  output logic                              addr_err
);

  localparam int BLK_AW       = $clog2(BLK_PER_PAGE);
  localparam int SUB_AW       = $clog2(BLK_PER_GRP);
  localparam int GRP_PER_PAGE = BLK_PER_PAGE / BLK_PER_GRP;
  localparam int GRP_AW       = $clog2(GRP_PER_PAGE);

  logic                    ctr_load, ctr_adv;
  logic                    eom_we, eom_wbit;
  logic [PAGE_AW-1:0]      page_w;
  logic [BLK_AW-1:0]       blk_w;
  logic [GRP_PER_PAGE-1:0] eom_row;

  prs_addr_ctr #(
    .NUM_PAGES   (NUM_PAGES),
    .PAGE_AW     (PAGE_AW),
    .BLK_PER_PAGE(BLK_PER_PAGE),
    .BLK_AW      (BLK_AW)
  ) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ctr_load),
    .load_page_i(start_page),
    .adv_i      (ctr_adv),
    .page_o     (page_w),
    .blk_o      (blk_w)
  );

  prs_eom_store #(
    .NUM_PAGES   (NUM_PAGES),
    .PAGE_AW     (PAGE_AW),
    .GRP_PER_PAGE(GRP_PER_PAGE),
    .GRP_AW      (GRP_AW)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (eom_we),
    .wpage_i(page_w),
    .wgrp_i (blk_w[BLK_AW-1:SUB_AW]),
    .wbit_i (eom_wbit),
    .rpage_i(page_w),
    .rrow_o (eom_row)
  );

  prs_ctrl #(
    .NUM_PAGES   (NUM_PAGES),
    .PAGE_AW     (PAGE_AW),
    .BLK_AW      (BLK_AW),
    .SUB_AW      (SUB_AW),
    .GRP_PER_PAGE(GRP_PER_PAGE),
    .GRP_AW      (GRP_AW)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_rec_i    (cmd_rec),
    .cmd_play_i   (cmd_play),
    .cmd_stop_i   (cmd_stop),
    .start_page_i (start_page),
    .blk_tick_i   (blk_tick),
    .cur_blk_i    (blk_w),
    .eom_row_i    (eom_row),
    .ctr_load_o   (ctr_load),
    .ctr_adv_o    (ctr_adv),
    .eom_we_o     (eom_we),
    .eom_wbit_o   (eom_wbit),
    .rec_active_o (rec_active),
    .play_active_o(play_active),
    .rec_done_o   (rec_done),
    .msg_irq_o    (msg_end_irq),
    .addr_err_o   (addr_err)
  );

  assign cur_page  = page_w;
  assign cur_block = blk_w;

  AST_ONE_MODE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rec_active && play_active)); // R11

  AST_NO_MOVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_active && !play_active && !cmd_rec && !cmd_play) |=> ($stable(cur_page) && $stable(cur_block))); // R10

endmodule

// File: tb/page_rec_seq_bench.sv
module page_rec_seq_bench;

  typedef struct packed {
    logic        rec;
    logic        play;
    logic        stop;
    logic        tick;
    logic [10:0] pg;
    logic        xr;
    logic        xp;
    logic        xd;
    logic        xi;
    logic        xe;
    logic [10:0] xpg;
    logic [4:0]  xb;
  } vec_t;

  function automatic vec_t mkv(int r, int p, int s, int t, int pg,
                               int xr, int xp, int xd, int xi, int xe, int xpg, int xb);
    vec_t v;
    v.rec  = 1'(r);
    v.play = 1'(p);
    v.stop = 1'(s);
    v.tick = 1'(t);
    v.pg   = 11'(pg);
    v.xr   = 1'(xr);
    v.xp   = 1'(xp);
    v.xd   = 1'(xd);
    v.xi   = 1'(xi);
    v.xe   = 1'(xe);
    v.xpg  = 11'(xpg);
    v.xb   = 5'(xb);
    return v;
  endfunction

  localparam int NV = 27;
  // rows 0-6: deferred stop (R2 R5); rows 7-16: re-record over marker, stop on edge (R6 R8);
  // rows 17-26: playback skips cleared group, interrupt on new end (R7 R8)
  localparam vec_t TBL [NV] = '{
    mkv(1,0,0,0,5, 1,0,0,0,0,5,0),
    mkv(0,0,0,1,0, 1,0,0,0,0,5,1),
    mkv(0,0,1,0,0, 1,0,0,0,0,5,1),
    mkv(0,0,0,1,0, 1,0,0,0,0,5,2),
    mkv(0,0,0,1,0, 1,0,0,0,0,5,3),
    mkv(0,0,0,1,0, 0,0,1,0,0,5,3),
    mkv(0,0,0,0,0, 0,0,0,0,0,5,3),
    mkv(1,0,0,0,5, 1,0,0,0,0,5,0),
    mkv(0,0,0,1,0, 1,0,0,0,0,5,1),
    mkv(0,0,0,1,0, 1,0,0,0,0,5,2),
    mkv(0,0,0,1,0, 1,0,0,0,0,5,3),
    mkv(0,0,0,1,0, 1,0,0,0,0,5,4),
    mkv(0,0,0,1,0, 1,0,0,0,0,5,5),
    mkv(0,0,0,1,0, 1,0,0,0,0,5,6),
    mkv(0,0,0,1,0, 1,0,0,0,0,5,7),
    mkv(0,0,1,1,0, 0,0,1,0,0,5,7),
    mkv(0,0,0,0,0, 0,0,0,0,0,5,7),
    mkv(0,1,0,0,5, 0,1,0,0,0,5,0),
    mkv(0,0,0,1,0, 0,1,0,0,0,5,1),
    mkv(0,0,0,1,0, 0,1,0,0,0,5,2),
    mkv(0,0,0,1,0, 0,1,0,0,0,5,3),
    mkv(0,0,0,1,0, 0,1,0,0,0,5,4),
    mkv(0,0,0,1,0, 0,1,0,0,0,5,5),
    mkv(0,0,0,1,0, 0,1,0,0,0,5,6),
    mkv(0,0,0,1,0, 0,1,0,0,0,5,7),
    mkv(0,0,0,1,0, 0,0,0,1,0,5,7),
    mkv(0,0,0,0,0, 0,0,0,0,0,5,7)
  };

  logic        clk;
  logic        rst_n;
  logic        cmd_rec, cmd_play, cmd_stop, blk_tick;
  logic [10:0] start_page;
  logic        rec_active, play_active, rec_done, msg_end_irq, addr_err;
  logic [10:0] cur_page;
  logic [4:0]  cur_block;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  page_rec_seq u_page_rec_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_rec    (cmd_rec),
    .cmd_play   (cmd_play),
    .cmd_stop   (cmd_stop),
    .start_page (start_page),
    .blk_tick   (blk_tick),
    .rec_active (rec_active),
    .play_active(play_active),
    .cur_page   (cur_page),
    .cur_block  (cur_block),
    .rec_done   (rec_done),
    .msg_end_irq(msg_end_irq),
    .addr_err   (addr_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic drive(input int r, input int p, input int s, input int t, input int pg);
    cmd_rec    = 1'(r);
    cmd_play   = 1'(p);
    cmd_stop   = 1'(s);
    blk_tick   = 1'(t);
    start_page = 11'(pg);
    @(posedge clk);
    @(negedge clk);
    cmd_rec  = 1'b0;
    cmd_play = 1'b0;
    cmd_stop = 1'b0;
    blk_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 1, 0);
  endtask

  // output vector order: rec_active play_active rec_done msg_end_irq addr_err cur_page cur_block
  task automatic expect_out(input string req, input int xr, input int xp, input int xd,
                            input int xi, input int xe, input int xpg, input int xb);
    logic [20:0] act, exp;
    act = {rec_active, play_active, rec_done, msg_end_irq, addr_err, cur_page, cur_block};
    exp = {1'(xr), 1'(xp), 1'(xd), 1'(xi), 1'(xe), 11'(xpg), 5'(xb)};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cmd_rec = 1'b0; cmd_play = 1'b0; cmd_stop = 1'b0; blk_tick = 1'b0;
    start_page = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 reset state", 0, 0, 0, 0, 0, 0, 0);

    // vector table: R2 R5 R6 R7 R8
    for (int k = 0; k < NV; k++) begin
      drive(int'(TBL[k].rec), int'(TBL[k].play), int'(TBL[k].stop), int'(TBL[k].tick), int'(TBL[k].pg));
      expect_out($sformatf("R2 R5 R6 R7 R8 table row %0d", k),
                 int'(TBL[k].xr), int'(TBL[k].xp), int'(TBL[k].xd), int'(TBL[k].xi),
                 int'(TBL[k].xe), int'(TBL[k].xpg), int'(TBL[k].xb));
    end

    // R4: out-of-range start pages
    drive(1, 0, 0, 0, 1888);
    expect_out("R4 record page 1888 refused", 0, 0, 0, 0, 1, 5, 7);
    drive(0, 1, 0, 0, 2047);
    expect_out("R4 play page 2047 refused", 0, 0, 0, 0, 1, 5, 7);
    drive(0, 0, 0, 0, 0);
    expect_out("R4 error held", 0, 0, 0, 0, 1, 5, 7);

    // R3 page wrap from last page; R4 error cleared; R10 commands ignored
    drive(1, 0, 0, 0, 1887);
    expect_out("R4 accepted start clears error", 1, 0, 0, 0, 0, 1887, 0);
    ticks(31);
    expect_out("R3 block 31 of last page", 1, 0, 0, 0, 0, 1887, 31);
    drive(0, 1, 0, 0, 7);
    expect_out("R10 play ignored while recording", 1, 0, 0, 0, 0, 1887, 31);
    drive(1, 0, 0, 0, 7);
    expect_out("R10 record ignored while recording", 1, 0, 0, 0, 0, 1887, 31);
    ticks(1);
    expect_out("R3 wrap to page 0", 1, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0);
    ticks(3);
    expect_out("R5 still recording to group end", 1, 0, 0, 0, 0, 0, 3);
    ticks(1);
    expect_out("R5 done at group end", 0, 0, 1, 0, 0, 0, 3);
    drive(0, 0, 0, 0, 0);
    expect_out("R5 done is one pulse", 0, 0, 0, 0, 0, 0, 3);

    // R10: stop during playback
    drive(0, 1, 0, 0, 0);
    ticks(1);
    drive(0, 0, 1, 0, 0);
    expect_out("R10 stop ends playback silently", 0, 0, 0, 0, 0, 0, 1);

    // R7: marker written by the wrap recording
    drive(0, 1, 0, 0, 0);
    ticks(3);
    expect_out("R7 playing up to marked group", 0, 1, 0, 0, 0, 0, 3);
    ticks(1);
    expect_out("R7 interrupt on marked group", 0, 0, 0, 1, 0, 0, 3);

    // R9: two-page message, playback crosses the page edge
    drive(1, 0, 0, 0, 10);
    ticks(36);
    expect_out("R3 recording crossed into page 11", 1, 0, 0, 0, 0, 11, 4);
    drive(0, 0, 1, 0, 0);
    ticks(4);
    expect_out("R5 two-page recording ended", 0, 0, 1, 0, 0, 11, 7);
    drive(0, 1, 0, 0, 10);
    ticks(39);
    expect_out("R9 playback crossed page without interrupt", 0, 1, 0, 0, 0, 11, 7);
    ticks(1);
    expect_out("R9 interrupt at end of page 11 group 1", 0, 0, 0, 1, 0, 11, 7);
    drive(0, 0, 0, 0, 0);
    expect_out("R11 interrupt is one pulse, no done", 0, 0, 0, 0, 0, 11, 7);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule